// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block sits behind the command decoder of a byte-wide flash array. It gathers the blocks that software asks to erase. It holds an acceptance window open while more requests may still arrive. Once the window closes, it walks through the chosen blocks one at a time. Each block confirm carries an 18-bit byte address. A built-in decoder maps that address onto one of seven blocks of a top-boot layout. A chip-erase request selects every block at once and starts work at once, with no window.

The physical erase of a block is not modelled here. The scheduler raises `erase_req` with the block index on `cur_blk`. The array side answers with a one-cycle `erase_ack` after its own fixed latency. The scheduler then moves on to the next selected block with the lowest index. Blocks whose protection bit is set are never selected.

A suspend request takes effect only at the next block boundary. The scheduler then parks with `erase_req` low until a resume arrives, so that the host can touch the blocks that are not being erased in the meantime. Three status outputs report the progress of an operation. `tmr_done` is low while the window runs and high once erasing has begun. `busy` covers the whole operation, and `suspended` marks the parked state.

Top module: `mb_erase_sched`

## Requirements
- R1: The address decodes to a block index in ascending address order, as follows:
  - 00000h-0FFFFh is index 0, 10000h-1FFFFh is index 1 and 20000h-2FFFFh is index 2.
  - 30000h-37FFFh is index 3.
  - 38000h-39FFFh is index 4 and 3A000h-3BFFFh is index 5.
  - 3C000h-3FFFFh is index 6.
  - The index of the block being erased appears on `cur_blk`.
- R2: When the scheduler is idle, a block confirm for an unprotected block opens the acceptance window. After the capturing edge, `busy` is 1, `tmr_done` is 0 and `erase_req` is 0.
- R3: Erasing starts exactly WIN clock edges after the last accepted confirm. From that edge on, `tmr_done` and `erase_req` are 1. Every accepted confirm inside the window restarts the full count.
- R4: The blocks selected inside the window are erased one after another, in ascending index order. Each block is erased once, and `cur_blk` advances on each accepted acknowledge.
- R5: A confirm for a block whose `prot` bit is set has no effect. It neither selects the block, nor opens the window, nor restarts the window.
- R6: A chip erase while idle selects every unprotected block. On the next edge it raises `erase_req` and `tmr_done`, with `cur_blk` set to the lowest unprotected index.
- R7: While erasing or suspended, block confirms and chip-erase requests are ignored.
- R8: A suspend during erasing takes effect at the next accepted acknowledge. On that edge `erase_req` falls, `suspended` rises and `cur_blk` shows the next block to erase. If no block remains, the operation simply finishes.
- R9: A resume while suspended raises `erase_req` and clears `suspended` on the next edge. Resume outside the suspended state and suspend outside erasing have no effect.
- R10: After the acknowledge of the last block, `busy`, `tmr_done` and `erase_req` are 0 from that edge on.
- R11: After reset, all outputs are 0.
- R12: An `erase_ack` while `erase_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_cfm | input | 1 | One-cycle block erase confirm |
| cfm_addr | input | 18 | Byte address carried by the confirm |
| chip_erase | input | 1 | One-cycle whole-array erase request |
| susp_req | input | 1 | One-cycle suspend command |
| resume_req | input | 1 | One-cycle resume command |
| prot | input | 7 | Protection bit per block index |
| erase_ack | input | 1 | Array reports that the current block is erased |
| cur_blk | output | 3 | Index of the block being erased or next to erase |
| erase_req | output | 1 | Asks the array to erase `cur_blk` |
| busy | output | 1 | An erase operation is open |
| tmr_done | output | 1 | Window closed, erasing has begun (low during the window) |
| suspended | output | 1 | Erase parked between blocks |

## Verification
The hardest situation to reach is a suspend that is still pending when the array's acknowledge lands. The request must be held back until the block boundary, and the scheduler must then park on the correct next block. The bench starts a chip erase and issues the suspend a couple of cycles later. Its array model acknowledges after a fixed latency, so the bench knows the exact cycle of the boundary. It checks that `suspended` is still low one cycle before that boundary and high right after it. While the scheduler is parked, the bench sends stray acknowledges and new confirms to show that the parked state holds, and then resumes to see the remaining order complete.

// File: rtl/mbes_pkg.sv
`timescale 1ns/1ps
package mbes_pkg;
  localparam int NUM_BLK   = 7;
  localparam int BLK_IDX_W = $clog2(NUM_BLK);

  typedef logic [BLK_IDX_W-1:0] blk_idx_t;
  typedef logic [NUM_BLK-1:0]   blk_mask_t;

  typedef enum logic [1:0] {
    SCH_IDLE   = 2'd0,
    SCH_WINDOW = 2'd1,
    SCH_ERASE  = 2'd2,
    SCH_HOLD   = 2'd3
  } sch_state_e;
endpackage

// File: rtl/mbes_addr_map.sv
`timescale 1ns/1ps
module mbes_addr_map
  import mbes_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr,
  output blk_idx_t          idx
);
  // Lower bound of blocks 1..6 in units of 1/32 of the address space.
  localparam int NUM_EDGE = NUM_BLK - 1;

  function automatic logic [ADDR_W-1:0] edge_addr(input int e);
    int frac;
    case (e)
      0:       frac = 8;
      1:       frac = 16;
      2:       frac = 24;
      3:       frac = 28;
      4:       frac = 29;
      default: frac = 30;
    endcase
    return ADDR_W'(frac) << (ADDR_W - 5);
  endfunction

  logic [NUM_EDGE-1:0] above;

  genvar g;
  generate
    for (g = 0; g < NUM_EDGE; g++) begin : g_edge
      assign above[g] = (addr >= edge_addr(g));
    end
  endgenerate

  // Boundaries are monotonic, so the count of passed boundaries is the index.
  assign idx = blk_idx_t'($countones(above));
endmodule

// File: rtl/mbes_lowest.sv
`timescale 1ns/1ps
module mbes_lowest #(
  parameter int N  = 7,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mbes_window.sv
`timescale 1ns/1ps
module mbes_window #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] TOP = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= TOP;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/mb_erase_sched.sv
`timescale 1ns/1ps
module mb_erase_sched
  import mbes_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int WIN_CYCLES = 4000,
  parameter bit TEST_MODE  = 1'b0,
  parameter int WIN_TEST   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 blk_cfm,
  input  logic [ADDR_W-1:0]    cfm_addr,
  input  logic                 chip_erase,
  input  logic                 susp_req,
  input  logic                 resume_req,
  input  logic [NUM_BLK-1:0]   prot,
  input  logic                 erase_ack,
  output logic [BLK_IDX_W-1:0] cur_blk,
  output logic                 erase_req,
  output logic                 busy,
  output logic                 tmr_done,
  output logic                 suspended
);
  localparam int WIN = TEST_MODE ? WIN_TEST : WIN_CYCLES;

  sch_state_e state_q;
  blk_mask_t  sel_q;
  blk_idx_t   cur_q;
  logic       req_q;
  logic       pend_q;

  blk_idx_t   dec_idx;
  logic       cfm_ok, accept, ack_ok, win_expired;
  logic       in_idle, in_win;
  blk_mask_t  clr_mask, sel_left, pick_src;
  logic       pick_found;
  blk_idx_t   pick_idx;

  mbes_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr (cfm_addr),
    .idx  (dec_idx)
  );

  assign in_idle = (state_q == SCH_IDLE);
  assign in_win  = (state_q == SCH_WINDOW);
  assign cfm_ok  = blk_cfm && !prot[dec_idx];
  assign accept  = cfm_ok && (in_idle || in_win);
  assign ack_ok  = erase_ack && req_q;

  mbes_window #(.WIN(WIN)) u_win (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .run     (in_win),
    .expired (win_expired)
  );

  always_comb begin
    clr_mask = ack_ok ? (blk_mask_t'(1) << cur_q) : '0;
    sel_left = sel_q & ~clr_mask;
    pick_src = in_idle ? ~prot : (sel_left & ~prot);
  end

  mbes_lowest #(.N(NUM_BLK), .IW(BLK_IDX_W)) u_pick (
    .mask  (pick_src),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCH_IDLE;
      sel_q   <= '0;
      cur_q   <= '0;
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        SCH_IDLE: begin
          if (chip_erase) begin
            if (pick_found) begin
              sel_q   <= ~prot;
              cur_q   <= pick_idx;
              req_q   <= 1'b1;
              state_q <= SCH_ERASE;
            end
          end else if (accept) begin
            sel_q   <= blk_mask_t'(1) << dec_idx;
            state_q <= SCH_WINDOW;
          end
        end
        SCH_WINDOW: begin
          if (accept) begin
            sel_q <= sel_q | (blk_mask_t'(1) << dec_idx);
          end else if (win_expired) begin
            if (pick_found) begin
              cur_q   <= pick_idx;
              req_q   <= 1'b1;
              state_q <= SCH_ERASE;
            end else begin
              sel_q   <= '0;
              state_q <= SCH_IDLE;
            end
          end
        end
        SCH_ERASE: begin
          if (susp_req) pend_q <= 1'b1;
          if (ack_ok) begin
            sel_q <= sel_left;
            if (!pick_found) begin
              sel_q   <= '0;
              cur_q   <= '0;
              req_q   <= 1'b0;
              pend_q  <= 1'b0;
              state_q <= SCH_IDLE;
            end else begin
              cur_q <= pick_idx;
              if (pend_q || susp_req) begin
                req_q   <= 1'b0;
                pend_q  <= 1'b0;
                state_q <= SCH_HOLD;
              end
            end
          end
        end
        SCH_HOLD: begin
          if (resume_req) begin
            req_q   <= 1'b1;
            state_q <= SCH_ERASE;
          end
        end
        default: state_q <= SCH_IDLE;
      endcase
    end
  end

  assign cur_blk   = cur_q;
  assign erase_req = req_q;
  assign busy      = (state_q != SCH_IDLE);
  assign tmr_done  = (state_q == SCH_ERASE) || (state_q == SCH_HOLD);
  assign suspended = (state_q == SCH_HOLD);

  AST_REQ_SELECTED: assert property (@(posedge clk) disable iff (rst)
    req_q |-> sel_q[cur_q]); // R4
  AST_WIN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy && !tmr_done) |-> !erase_req); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    suspended |-> !erase_req); // R8
  AST_SUSP_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(suspended) |-> $past(ack_ok)); // R8
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (tmr_done && !ack_ok) |=> $stable(sel_q)); // R7
  AST_CHIP_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (in_idle && chip_erase && pick_found) |=> (erase_req && tmr_done)); // R6
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sel_q == '0 && !erase_req)); // R10
endmodule

// File: tb/mb_erase_sched_bench.sv
`timescale 1ns/1ps
module mb_erase_sched_bench;
  localparam int WIN_T = 16;
  localparam int LAT   = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_cfm = 1'b0;
  logic [17:0] cfm_addr = '0;
  logic        chip_erase = 1'b0;
  logic        susp_req = 1'b0;
  logic        resume_req = 1'b0;
  logic [6:0]  prot = '0;
  logic        mdl_ack = 1'b0;
  logic        man_ack = 1'b0;
  logic        erase_ack;
  logic [2:0]  cur_blk;
  logic        erase_req, busy, tmr_done, suspended;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [2:0] log_q [0:31];
  int log_n = 0;
  int mcnt = 0;

  assign erase_ack = mdl_ack | man_ack;

  always #10 clk = ~clk;

  mb_erase_sched #(.ADDR_W(18), .WIN_CYCLES(4000), .TEST_MODE(1'b1), .WIN_TEST(WIN_T))
  u_mb_erase_sched (
    .clk(clk), .rst(rst), .blk_cfm(blk_cfm), .cfm_addr(cfm_addr),
    .chip_erase(chip_erase), .susp_req(susp_req), .resume_req(resume_req),
    .prot(prot), .erase_ack(erase_ack), .cur_blk(cur_blk),
    .erase_req(erase_req), .busy(busy), .tmr_done(tmr_done), .suspended(suspended)
  );

  // Array model: acknowledges LAT cycles after the request, logging the block.
  initial begin
    forever begin
      @(negedge clk);
      if (mdl_ack) begin
        mdl_ack = 1'b0;
        mcnt = 0;
      end else if (erase_req) begin
        mcnt++;
        if (mcnt == LAT) begin
          mdl_ack = 1'b1;
          if (log_n < 32) log_q[log_n] = cur_blk;
          log_n++;
        end
      end else begin
        mcnt = 0;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_cfm(input logic [17:0] a);
    cfm_addr = a; blk_cfm = 1'b1; step(); blk_cfm = 1'b0;
  endtask
  task automatic pulse_chip();
    chip_erase = 1'b1; step(); chip_erase = 1'b0;
  endtask
  task automatic pulse_susp();
    susp_req = 1'b1; step(); susp_req = 1'b0;
  endtask
  task automatic pulse_resume();
    resume_req = 1'b1; step(); resume_req = 1'b0;
  endtask
  task automatic pulse_ack();
    man_ack = 1'b1; step(); man_ack = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) step();
  endtask

  task automatic chk_log(input string req, input int n, input logic [2:0] e0,
                         input logic [2:0] e1, input logic [2:0] e2, input logic [2:0] e3,
                         input logic [2:0] e4, input logic [2:0] e5, input logic [2:0] e6);
    logic [2:0] ex [0:6];
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3; ex[4] = e4; ex[5] = e5; ex[6] = e6;
    chk(log_n == n, req, "erased block count", log_n, n);
    for (int i = 0; i < n && i < log_n; i++)
      chk(log_q[i] == ex[i], req, $sformatf("erase order slot %0d", i), log_q[i], ex[i]);
  endtask

  task automatic t_reset();
    chk(busy == 0 && erase_req == 0, "R11", "busy/req after reset", {busy, erase_req}, 0);
    chk(tmr_done == 0 && suspended == 0, "R11", "tmr/susp after reset", {tmr_done, suspended}, 0);
    chk(cur_blk == 0, "R11", "cur_blk after reset", cur_blk, 0);
    pulse_ack();
    chk(busy == 0 && cur_blk == 0, "R12", "stray ack while idle", {busy, cur_blk}, 0);
  endtask

  task automatic t_decode();
    logic [17:0] a [0:13];
    logic [2:0]  e [0:13];
    a[0]  = 18'h00000; e[0]  = 3'd0;  a[1]  = 18'h0FFFF; e[1]  = 3'd0;
    a[2]  = 18'h10000; e[2]  = 3'd1;  a[3]  = 18'h1FFFF; e[3]  = 3'd1;
    a[4]  = 18'h20000; e[4]  = 3'd2;  a[5]  = 18'h2FFFF; e[5]  = 3'd2;
    a[6]  = 18'h30000; e[6]  = 3'd3;  a[7]  = 18'h37FFF; e[7]  = 3'd3;
    a[8]  = 18'h38000; e[8]  = 3'd4;  a[9]  = 18'h39FFF; e[9]  = 3'd4;
    a[10] = 18'h3A000; e[10] = 3'd5;  a[11] = 18'h3BFFF; e[11] = 3'd5;
    a[12] = 18'h3C000; e[12] = 3'd6;  a[13] = 18'h3FFFF; e[13] = 3'd6;
    for (int k = 0; k < 14; k++) begin
      log_n = 0;
      pulse_cfm(a[k]);
      wait_idle();
      chk(log_n == 1 && log_q[0] == e[k], "R1", $sformatf("decode of %h", a[k]),
          log_q[0], e[k]);
    end
  endtask

  task automatic t_window();
    log_n = 0;
    pulse_cfm(18'h00010);
    chk(busy == 1 && tmr_done == 0 && erase_req == 0, "R2", "window open",
        {busy, tmr_done, erase_req}, 3'b100);
    repeat (8) step();
    pulse_cfm(18'h20000);
    for (int i = 1; i < WIN_T; i++) step();
    chk(tmr_done == 0 && erase_req == 0, "R3", "window restarted, not yet expired",
        {tmr_done, erase_req}, 0);
    step();
    chk(tmr_done == 1 && erase_req == 1 && cur_blk == 0, "R3", "erase starts at WIN",
        {tmr_done, erase_req, cur_blk}, {2'b11, 3'd0});
    wait_idle();
    chk_log("R3", 2, 3'd0, 3'd2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_multi();
    log_n = 0;
    pulse_cfm(18'h3C123);
    pulse_cfm(18'h2ABCD);
    pulse_cfm(18'h38004);
    pulse_cfm(18'h00FFF);
    wait_idle();
    chk_log("R4", 4, 3'd0, 3'd2, 3'd4, 3'd6, 0, 0, 0);
    chk(tmr_done == 0 && erase_req == 0 && suspended == 0, "R10", "idle after multi",
        {tmr_done, erase_req, suspended}, 0);
  endtask

  task automatic t_prot();
    log_n = 0;
    prot = 7'b0001000;
    pulse_cfm(18'h30000);
    chk(busy == 0, "R5", "protected confirm does not open window", busy, 0);
    pulse_cfm(18'h10000);
    repeat (5) step();
    pulse_cfm(18'h37FFF);
    for (int i = 0; i < WIN_T - 7; i++) step();
    chk(tmr_done == 0, "R5", "one edge before original expiry", tmr_done, 0);
    step();
    chk(tmr_done == 1 && cur_blk == 1, "R5", "protected confirm did not restart",
        {tmr_done, cur_blk}, {1'b1, 3'd1});
    wait_idle();
    chk_log("R5", 1, 3'd1, 0, 0, 0, 0, 0, 0);
    prot = '0;
  endtask

  task automatic t_chip();
    log_n = 0;
    prot = 7'b0100100;
    pulse_chip();
    chk(erase_req == 1 && tmr_done == 1 && busy == 1 && cur_blk == 0, "R6",
        "chip erase starts at once", {busy, tmr_done, erase_req, cur_blk}, {3'b111, 3'd0});
    wait_idle();
    chk_log("R6", 5, 3'd0, 3'd1, 3'd3, 3'd4, 3'd6, 0, 0);
    prot = '0;
  endtask

  task automatic t_ignore();
    log_n = 0;
    pulse_cfm(18'h25555);
    for (int i = 1; i < WIN_T; i++) step();
    step();
    chk(erase_req == 1 && cur_blk == 2, "R7", "single block erase started",
        {erase_req, cur_blk}, {1'b1, 3'd2});
    pulse_cfm(18'h3A000);
    pulse_chip();
    step(); step();
    chk(busy == 1 && erase_req == 1, "R10", "still erasing before ack", {busy, erase_req}, 2'b11);
    step();
    chk(busy == 0 && erase_req == 0 && tmr_done == 0, "R10", "idle on last ack edge",
        {busy, erase_req, tmr_done}, 0);
    repeat (WIN_T + 4) step();
    chk(busy == 0, "R7", "confirm/chip during erase not remembered", busy, 0);
    chk_log("R7", 1, 3'd2, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_suspend();
    log_n = 0;
    pulse_chip();
    pulse_susp();
    chk(suspended == 0 && erase_req == 1, "R8", "suspend waits for boundary",
        {suspended, erase_req}, 2'b01);
    step(); step(); step();
    chk(suspended == 0 && cur_blk == 0, "R8", "one cycle before boundary",
        {suspended, cur_blk}, 0);
    step();
    chk(suspended == 1 && erase_req == 0 && cur_blk == 1 && busy == 1 && tmr_done == 1,
        "R8", "parked at boundary", {suspended, erase_req, cur_blk, busy, tmr_done},
        {2'b10, 3'd1, 2'b11});
    repeat (10) step();
    chk(suspended == 1 && erase_req == 0, "R8", "stays parked", {suspended, erase_req}, 2'b10);
    pulse_ack();
    step();
    chk(suspended == 1 && cur_blk == 1, "R12", "stray ack while parked",
        {suspended, cur_blk}, {1'b1, 3'd1});
    pulse_cfm(18'h00000);
    pulse_chip();
    pulse_susp();
    chk(suspended == 1 && log_n == 1, "R7", "commands ignored while parked",
        {suspended, 8'(log_n)}, {1'b1, 8'd1});
    pulse_resume();
    chk(erase_req == 1 && suspended == 0 && cur_blk == 1, "R9", "resume continues",
        {erase_req, suspended, cur_blk}, {2'b10, 3'd1});
    wait_idle();
    chk_log("R9", 7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6);
    pulse_resume();
    chk(busy == 0 && erase_req == 0, "R9", "resume while idle ignored", {busy, erase_req}, 0);
  endtask

  task automatic t_suspend_edges();
    log_n = 0;
    pulse_cfm(18'h3C000);
    pulse_susp();
    for (int i = 0; i < WIN_T + LAT + 4; i++) step();
    chk(busy == 0 && suspended == 0, "R9", "suspend in window ignored", {busy, suspended}, 0);
    chk_log("R9", 1, 3'd6, 0, 0, 0, 0, 0, 0);
    log_n = 0;
    prot = 7'b0111111;
    pulse_chip();
    pulse_susp();
    wait_idle();
    chk(busy == 0 && suspended == 0, "R8", "suspend on last block just finishes",
        {busy, suspended}, 0);
    chk_log("R8", 1, 3'd6, 0, 0, 0, 0, 0, 0);
    prot = '0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_decode();
    t_window();
    t_multi();
    t_prot();
    t_chip();
    t_ignore();
    t_suspend();
    t_suspend_edges();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule